// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. A start strobe captures the requested column and a configuration taken from the mode-register word: a 3-bit burst-length code and a 1-bit ordering bit. From the next cycle on, the block emits one column per clock with a valid flag and a last flag. The first column is always the requested word, so the critical word comes first.

Fixed bursts of 1, 2, 4 or 8 words wrap inside the aligned block that holds the requested column. The ordering is either sequential, where a beat count is added modulo the burst length, or interleaved, where the beat count is XORed into the low bits. A full-row burst counts sequentially through the row and wraps at the row width. It only ends when the interrupt input stops it. The stop input can also cut a fixed burst short. A new start strobe restarts the generator at any time.

Top module: `sdram_burst_col_gen`

## Requirements
- R1: While reset is high and on the cycle after it, `beat_valid`, `beat_last` and `cfg_err` are 0.
- R2: The cycle after `start` is sampled high, `beat_valid` is 1 and `col_addr` equals the sampled `start_col`.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 valid beats in consecutive cycles, followed by `beat_valid` = 0.
- R4: With `burst_type` = 0, beat k carries low bits ((start + k) mod L), where L is the burst length. The column bits above the low log2(L) bits stay equal to those of the start column.
- R5: With `burst_type` = 1 and L of 4 or 8, beat k carries low bits (start XOR k). For L of 1 or 2, `burst_type` does not change the order.
- R6: Length code 3'b111 selects a full-row burst. Beat k is (start + k) mod 2^COL_W, and it runs with `beat_last` = 0 until it is stopped.
- R7: A full-row request with `burst_type` = 1 raises `cfg_err` for the whole burst and uses sequential order.
- R8: The reserved length codes 3'b100, 3'b101 and 3'b110 run a single beat with `cfg_err` = 1.
- R9: When `stop` is high during a valid beat without `start`, `beat_last` is 1 in that cycle and `beat_valid` is 0 on the next cycle.
- R10: In a burst that is not stopped, `beat_last` is 1 only on the final beat.
- R11: A `start` during a burst, even together with `stop`, abandons the old burst. The next cycle shows the new start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new burst |
| start_col | input | COL_W | Requested (critical) column |
| len_code | input | 3 | Burst-length code from the mode word |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| stop | input | 1 | Interrupt that ends the running burst |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Final beat of the burst |
| cfg_err | output | 1 | Running burst came from an illegal configuration |

## Verification
Two cases are the hardest to reach from the ports: a full-row burst that crosses the top of the row, and a start strobe that arrives in the same cycle as a stop while an old burst is still running. The bench starts a full-row burst a few columns below the row end and lets it run past the wrap before stopping it. It then raises start and stop together in the middle of an eight-word burst and checks that the new column appears.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef struct packed {
        logic       full;     // run until stopped
        logic       xor_ord;  // interleaved low bits
        logic       err;      // illegal request seen
        logic [3:0] len_m1;   // burst length minus one (fixed bursts)
    } burst_cfg_t;

    function automatic burst_cfg_t decode_mode(input logic [2:0] code, input logic btype);
        burst_cfg_t c;
        c = '0;
        case (code)
            3'b000: c.len_m1 = 4'd0;
            3'b001: c.len_m1 = 4'd1;
            3'b010: c.len_m1 = 4'd3;
            3'b011: c.len_m1 = 4'd7;
            3'b111: c.full   = 1'b1;
            default: begin
                c.len_m1 = 4'd0;
                c.err    = 1'b1;
            end
        endcase
        if (c.full && btype) c.err = 1'b1;
        c.xor_ord = btype && !c.full;
        return c;
    endfunction

endpackage

// File: rtl/bca_cfg_decode.sv
module bca_cfg_decode
    import burst_addr_pkg::*;
(
    input  logic [2:0] len_code,
    input  logic       burst_type,
    output burst_cfg_t cfg
);
    always_comb cfg = decode_mode(len_code, burst_type);
endmodule

// File: rtl/bca_beat_ctrl.sv
module bca_beat_ctrl
    import burst_addr_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  burst_cfg_t       cfg_in,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output burst_cfg_t       cfg_q,
    output logic             last
);
    logic final_beat;

    always_comb begin
        final_beat = !cfg_q.full && (beat == COL_W'(cfg_q.len_m1));
        last       = active && (final_beat || stop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat   <= '0;
            cfg_q  <= cfg_in;
        end else if (active) begin
            if (last) active <= 1'b0;
            else      beat   <= beat + 1'b1;
        end
    end

    a_r3_beat_bound: assert property (@(posedge clk) disable iff (rst)
        active && !cfg_q.full |-> beat <= COL_W'(cfg_q.len_m1));

    a_r6_full_keeps_running: assert property (@(posedge clk) disable iff (rst)
        active && cfg_q.full && !stop && !start |=> active);

    a_r10_fixed_ends_on_last: assert property (@(posedge clk) disable iff (rst)
        active && !last && !start |=> active);
endmodule

// File: rtl/bca_col_compose.sv
module bca_col_compose
    import burst_addr_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask, low_seq, low_xor, low;

    always_comb begin
        mask    = cfg.full ? '1 : COL_W'(cfg.len_m1);
        low_seq = base + beat;
        low_xor = base ^ beat;
        low     = cfg.xor_ord ? low_xor : low_seq;
        col     = (base & ~mask) | (low & mask);
    end
endmodule

// File: rtl/sdram_burst_col_gen.sv
module sdram_burst_col_gen
    import burst_addr_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             burst_type,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             cfg_err
);
    burst_cfg_t       cfg_dec, cfg_run;
    logic [COL_W-1:0] beat, base_q;
    logic             active;

    bca_cfg_decode u_dec (
        .len_code   (len_code),
        .burst_type (burst_type),
        .cfg        (cfg_dec)
    );

    bca_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .stop   (stop),
        .cfg_in (cfg_dec),
        .active (active),
        .beat   (beat),
        .cfg_q  (cfg_run),
        .last   (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst)        base_q <= '0;
        else if (start) base_q <= start_col;
    end

    bca_col_compose #(.COL_W(COL_W)) u_comp (
        .base (base_q),
        .beat (beat),
        .cfg  (cfg_run),
        .col  (col_addr)
    );

    assign beat_valid = active;
    assign cfg_err    = active && cfg_run.err;

    a_r2_critical_first: assert property (@(posedge clk) disable iff (rst)
        start |=> beat_valid && col_addr == $past(start_col));

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
        beat_valid && stop && !start |=> !beat_valid);

    a_r4_upper_held: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !start && !beat_last |=>
        ((col_addr ^ $past(col_addr)) & ~(cfg_run.full ? {COL_W{1'b1}} : COL_W'(cfg_run.len_m1))) == '0);

    a_r7_full_is_sequential: assert property (@(posedge clk) disable iff (rst)
        beat_valid && cfg_run.full && !start && !beat_last |=> col_addr == $past(col_addr) + 1'b1);
endmodule

// File: tb/sdram_burst_col_gen_bench.sv
module sdram_burst_col_gen_bench;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0, burst_type = 1'b0, stop = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = '0;
    logic [COL_W-1:0] col_addr;
    logic             beat_valid, beat_last, cfg_err;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    sdram_burst_col_gen #(.COL_W(COL_W)) u_sdram_burst_col_gen (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .burst_type(burst_type), .stop(stop),
        .col_addr(col_addr), .beat_valid(beat_valid), .beat_last(beat_last),
        .cfg_err(cfg_err)
    );

    // {len_code[2:0], burst_type, start_col[7:0]}
    localparam logic [11:0] VEC [9] = '{
        {3'b000, 1'b0, 8'h5A}, {3'b001, 1'b0, 8'h37}, {3'b001, 1'b1, 8'h36},
        {3'b010, 1'b0, 8'h1D}, {3'b010, 1'b1, 8'h1D}, {3'b011, 1'b0, 8'hC5},
        {3'b011, 1'b1, 8'hC5}, {3'b011, 1'b1, 8'h83}, {3'b010, 1'b1, 8'hF2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int code, input int bt, input int c, input int k);
        int len, lo;
        len = 1 << code;
        lo  = c % len;
        if (bt == 1 && len >= 4) lo = lo ^ k;
        else                     lo = (lo + k) % len;
        return c - (c % len) + lo;
    endfunction

    task automatic launch(input logic [2:0] code, input logic bt, input logic [7:0] c);
        start = 1'b1; len_code = code; burst_type = bt; start_col = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #5000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!beat_valid && !beat_last && !cfg_err, "R1", beat_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!beat_valid && !beat_last && !cfg_err, "R1", beat_valid, 0);

        // table of fixed bursts: R2 R3 R4 R5 R10
        for (int v = 0; v < 9; v++) begin
            int code, bt, c, len;
            code = int'(VEC[v][11:9]); bt = int'(VEC[v][8]); c = int'(VEC[v][7:0]);
            len = 1 << code;
            launch(VEC[v][11:9], VEC[v][8], VEC[v][7:0]);
            for (int k = 0; k < len; k++) begin
                chk(beat_valid == 1'b1, "R3", beat_valid, 1);
                chk(int'(col_addr) == exp_col(code, bt, c, k), bt ? "R5" : "R4",
                    col_addr, exp_col(code, bt, c, k));
                chk(beat_last == (k == len - 1), "R10", beat_last, k == len - 1);
                @(negedge clk);
            end
            chk(!beat_valid, "R3", beat_valid, 0);
        end

        // full row, crossing the row end: R6
        launch(3'b111, 1'b0, 8'hFC);
        for (int k = 0; k < 10; k++) begin
            chk(int'(col_addr) == ((252 + k) % 256), "R6", col_addr, (252 + k) % 256);
            chk(beat_valid && !beat_last && !cfg_err, "R6", beat_last, 0);
            @(negedge clk);
        end
        stop = 1'b1; #1;
        chk(beat_last == 1'b1, "R9", beat_last, 1);
        @(negedge clk); stop = 1'b0;
        chk(!beat_valid, "R9", beat_valid, 0);

        // full row with interleave asked: R7
        launch(3'b111, 1'b1, 8'h12);
        for (int k = 0; k < 4; k++) begin
            chk(int'(col_addr) == 18 + k, "R7", col_addr, 18 + k);
            chk(cfg_err == 1'b1, "R7", cfg_err, 1);
            @(negedge clk);
        end
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk(!beat_valid && !cfg_err, "R7", cfg_err, 0);

        // reserved codes: R8
        for (int r = 4; r < 7; r++) begin
            launch(3'(r), 1'b0, 8'h44);
            chk(beat_valid && beat_last && cfg_err && col_addr == 8'h44, "R8", col_addr, 8'h44);
            @(negedge clk);
            chk(!beat_valid, "R8", beat_valid, 0);
        end

        // stop mid fixed burst: R9
        launch(3'b011, 1'b0, 8'h00);
        @(negedge clk);
        stop = 1'b1; #1;
        chk(beat_last && col_addr == 8'h01, "R9", col_addr, 1);
        @(negedge clk); stop = 1'b0;
        chk(!beat_valid, "R9", beat_valid, 0);

        // restart with start and stop together: R11
        launch(3'b011, 1'b0, 8'h20);
        @(negedge clk);
        stop = 1'b1;
        launch(3'b001, 1'b0, 8'h09);
        stop = 1'b0;
        chk(beat_valid && col_addr == 8'h09, "R11", col_addr, 8'h09);
        @(negedge clk);
        chk(beat_last && col_addr == 8'h08, "R11", col_addr, 8'h08);
        @(negedge clk);
        chk(!beat_valid, "R11", beat_valid, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule